// File: doc/BRIEF.md
# Exp-Golomb Bitstream Writer

This block turns integer syntax values into Exp-Golomb code words and packs them, most significant bit first, into a stream of bytes. A producer offers one value at a time with a signed/unsigned select over a valid/ready handshake. The value passes through two registered arithmetic stages. The first maps it to a code number. The second finds the code length. The code is then moved into a partial-byte register, as many bits per cycle as the current byte has room for.

A counter of free bit positions tracks the byte being built. Each time that byte fills, it appears on `out_byte` with a one-cycle `out_valid` strobe and the write pointer advances. A programmed end pointer bounds the output. Once the write pointer equals it, the block stops writing and holds back the producer. A flush request closes a partial byte by padding it with zero bits.

Back-pressure rules: a value is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until every bit of the code has been placed into bytes, and it stays low for as long as the buffer is full. The producer must hold its value stable while `in_valid` is high and `in_ready` is low. The output side has no back-pressure.

Top module: `eg_writer`

## Requirements
- R1: An unsigned value v (0 to 2^VAL_W-2) is coded as n zero bits followed by the n+1 bit binary form of v+1, where n = floor(log2(v+1)). The longest code is 2*VAL_W-1 bits.
- R2: With `in_signed` high, `in_value` is a two's-complement number k (magnitude at most 2^(VAL_W-1)-1). It is first mapped to 2k-1 when k > 0 and to -2k when k <= 0, and the result is coded as in R1.
- R3: Successive codes are concatenated with no gaps, most significant bit first, across byte boundaries. Bit 7 of each byte holds the earliest bit.
- R4: Each completed byte is presented on `out_byte` with `out_valid` high for exactly one cycle, and `wr_ptr` increments by one in that same cycle.
- R5: When `wr_ptr` equals `end_ptr`, `full` is high, no further bytes are emitted, and `in_ready` is low.
- R6: After a value is accepted, `in_ready` is low in the next cycle and stays low until the code has been fully packed.
- R7: A `flush` pulse seen while `in_ready` is high and `in_valid` is low emits the pending partial byte. The valid bits are in the upper positions and the rest are zero, the pointer advances, and the next code starts a fresh byte. A flush with no pending bits emits nothing.
- R8: After reset, `wr_ptr` is 0, `out_valid` and `full` are low (for a non-zero `end_ptr`), and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer has a value |
| in_ready | output | 1 | Block will take a value on this edge |
| in_value | input | VAL_W | Value to code |
| in_signed | input | 1 | 1: signed mapping, 0: unsigned |
| flush | input | 1 | Pad and emit the partial byte |
| end_ptr | input | PTR_W | Byte position at which writing stops |
| out_valid | output | 1 | One-cycle strobe for a finished byte |
| out_byte | output | 8 | Finished byte |
| wr_ptr | output | PTR_W | Number of bytes written |
| full | output | 1 | Write pointer has reached the end pointer |

## Verification
The bench uses the default VAL_W of 16, so the longest 31-bit code and the signed magnitude limit of 32767 are both exercised. It widens PTR_W to 12 so that a sweep of every unsigned value from 0 to 300 and every signed value from -150 to 150 fits in the buffer without wrapping. The bench builds its expected bit string arithmetically and compares every emitted byte against it. A second run with an end pointer of 3 cuts a 31-bit code off mid-word to exercise the stall at the end of the buffer.

// File: rtl/eg_pkg.sv
package eg_pkg;
  localparam int unsigned BYTE_BITS = 8;
  typedef logic [BYTE_BITS-1:0] byte_t;
endpackage

// File: rtl/eg_map.sv
module eg_map #(
  parameter int unsigned VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [VAL_W-1:0] value,
  input  logic             is_signed,
  output logic [VAL_W-1:0] num
);
  logic [VAL_W:0] k_ext;
  logic [VAL_W:0] num_wide;
  logic           k_pos;

  always_comb begin
    k_ext = {value[VAL_W-1], value};
    k_pos = !k_ext[VAL_W] && (k_ext != '0);
    if (is_signed) begin
      if (k_pos) num_wide = k_ext << 1;
      else       num_wide = (VAL_W+1)'(1) - (k_ext << 1);
    end else begin
      num_wide = {1'b0, value} + (VAL_W+1)'(1);
    end
    num = num_wide[VAL_W-1:0];
  end

  // R1 R2: an accepted value must stay inside the supported range
  assert_num_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!num_wide[VAL_W] && num_wide != '0));
endmodule

// File: rtl/eg_len.sv
module eg_len #(
  parameter int unsigned VAL_W = 16,
  localparam int unsigned LW = $clog2(2*VAL_W)
) (
  input  logic [VAL_W-1:0] num,
  output logic [LW-1:0]    len
);
  logic [LW-1:0] msb;

  always_comb begin
    msb = '0;
    for (int i = 0; i < VAL_W; i++) begin
      if (num[i]) msb = LW'(i);
    end
    len = (msb << 1) + LW'(1);
  end
endmodule

// File: rtl/eg_packer.sv
module eg_packer
  import eg_pkg::*;
#(
  parameter int unsigned VAL_W = 16,
  parameter int unsigned PTR_W = 8,
  localparam int unsigned LW = $clog2(2*VAL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] load_code,
  input  logic [LW-1:0]    load_len,
  input  logic             flush_go,
  input  logic [PTR_W-1:0] end_ptr,
  output logic             busy,
  output logic             full,
  output logic             out_valid,
  output byte_t            out_byte,
  output logic [PTR_W-1:0] wr_ptr
);
  logic [VAL_W-1:0] code_q;
  logic [LW-1:0]    rem_q;
  logic [3:0]       free_q;
  byte_t            part_q;
  logic [LW-1:0]    free_ext;
  logic [LW-1:0]    take;
  byte_t            chunk;
  logic [15:0]      joined;
  logic [3:0]       free_nxt;

  assign busy = (rem_q != '0);
  assign full = (wr_ptr == end_ptr);

  always_comb begin
    free_ext = LW'(free_q);
    take     = (rem_q < free_ext) ? rem_q : free_ext;
    chunk    = byte_t'(code_q >> (rem_q - take)) &
               byte_t'((16'(1) << take) - 16'(1));
    joined   = (16'(part_q) << take) | 16'(chunk);
    free_nxt = free_q - 4'(take);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q    <= '0;
      rem_q     <= '0;
      free_q    <= 4'(BYTE_BITS);
      part_q    <= '0;
      wr_ptr    <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (load) begin
        code_q <= load_code;
        rem_q  <= load_len;
      end else if (busy && !full) begin
        rem_q <= rem_q - take;
        if (free_nxt == '0) begin
          out_byte  <= joined[7:0];
          out_valid <= 1'b1;
          part_q    <= '0;
          free_q    <= 4'(BYTE_BITS);
          wr_ptr    <= wr_ptr + PTR_W'(1);
        end else begin
          part_q <= joined[7:0];
          free_q <= free_nxt;
        end
      end else if (flush_go && free_q != 4'(BYTE_BITS)) begin
        out_byte  <= part_q << free_q;
        out_valid <= 1'b1;
        part_q    <= '0;
        free_q    <= 4'(BYTE_BITS);
        wr_ptr    <= wr_ptr + PTR_W'(1);
      end
    end
  end

  // R3: the free-bit counter always names a real bit slot
  assert_free_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q != '0) && (free_q <= 4'(BYTE_BITS)));
  // R6: a code in flight always makes progress unless the buffer is full
  assert_progress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !full) |=> (rem_q < $past(rem_q)));
  // R4: every byte strobe comes with a single pointer step
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wr_ptr == $past(wr_ptr) + PTR_W'(1)));
  // R5: nothing is written while the buffer is full
  assert_no_write_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !out_valid);
endmodule

// File: rtl/eg_writer.sv
module eg_writer
  import eg_pkg::*;
#(
  parameter int unsigned VAL_W = 16,
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VAL_W-1:0] in_value,
  input  logic             in_signed,
  input  logic             flush,
  input  logic [PTR_W-1:0] end_ptr,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             full
);
  localparam int unsigned LW = $clog2(2*VAL_W);

  logic             accept;
  logic             flush_go;
  logic             busy;
  logic [VAL_W-1:0] map_num;
  logic [VAL_W-1:0] s1_num;
  logic             s1_vld;
  logic [LW-1:0]    s1_len;
  byte_t            byte_w;

  assign in_ready = !s1_vld && !busy && !full;
  assign accept   = in_valid && in_ready;
  assign flush_go = flush && in_ready && !in_valid;
  assign out_byte = byte_w;

  eg_map #(.VAL_W(VAL_W)) u_map (
    .clk(clk), .rst_n(rst_n), .take(accept),
    .value(in_value), .is_signed(in_signed), .num(map_num)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_num <= '0;
    end else if (accept) begin
      s1_vld <= 1'b1;
      s1_num <= map_num;
    end else if (s1_vld) begin
      s1_vld <= 1'b0;
    end
  end

  eg_len #(.VAL_W(VAL_W)) u_len (.num(s1_num), .len(s1_len));

  eg_packer #(.VAL_W(VAL_W), .PTR_W(PTR_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .load(s1_vld), .load_code(s1_num),
    .load_len(s1_len), .flush_go(flush_go), .end_ptr(end_ptr),
    .busy(busy), .full(full), .out_valid(out_valid),
    .out_byte(byte_w), .wr_ptr(wr_ptr)
  );

  // R6: an accepted value closes the input for the following cycle
  assert_accept_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (s1_vld && !in_ready));
endmodule

// File: tb/eg_writer_bench.sv
module eg_writer_bench;
  localparam int VAL_W = 16;
  localparam int PTR_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [VAL_W-1:0] in_value = '0;
  logic             in_signed = 1'b0;
  logic             flush = 1'b0;
  logic [PTR_W-1:0] end_ptr = '1;
  logic             out_valid;
  logic [7:0]       out_byte;
  logic [PTR_W-1:0] wr_ptr;
  logic             full;

  int tests = 0;
  int fails = 0;
  int cap_n = 0;
  int base = 0;
  int nbits = 0;
  logic [7:0] cap [0:4095];
  logic       exp_bits [0:32767];

  always #10 clk = ~clk;

  eg_writer #(.VAL_W(VAL_W), .PTR_W(PTR_W)) u_eg_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_signed(in_signed), .flush(flush),
    .end_ptr(end_ptr), .out_valid(out_valid), .out_byte(out_byte),
    .wr_ptr(wr_ptr), .full(full)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      cap[cap_n] = out_byte;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_code(input int m);
    int num = m + 1;
    int n = 0;
    while ((num >> (n + 1)) != 0) n++;
    for (int i = 0; i < n; i++) begin exp_bits[nbits] = 1'b0; nbits++; end
    for (int i = n; i >= 0; i--) begin exp_bits[nbits] = num[i]; nbits++; end
  endtask

  task automatic send(input int v, input bit sgn, input bit chk_ready);
    int m;
    @(negedge clk);
    in_valid  = 1'b1;
    in_signed = sgn;
    in_value  = VAL_W'(v);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (chk_ready) check("R6 ready low after accept", 32'(in_ready), 32'd0);
    if (!sgn) m = v;
    else if (v > 0) m = 2 * v - 1;
    else m = -2 * v;
    push_code(m);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic do_flush();
    wait_idle();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    while ((nbits % 8) != 0) begin exp_bits[nbits] = 1'b0; nbits++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req, input int from_b, input int to_b);
    for (int b = from_b; b < to_b; b++) begin
      logic [7:0] e;
      for (int i = 0; i < 8; i++) e[7-i] = exp_bits[8*b + i];
      check(req, 32'(cap[base + b]), 32'(e));
    end
  endtask

  task automatic do_reset(input int endp);
    @(negedge clk);
    rst_n = 1'b0;
    end_ptr = PTR_W'(endp);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base = cap_n;
    nbits = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int mark;
    do_reset(4095);
    @(negedge clk);
    check("R8 reset wr_ptr", 32'(wr_ptr), 32'd0);
    check("R8 reset out_valid", 32'(out_valid), 32'd0);
    check("R8 reset full", 32'(full), 32'd0);
    check("R8 reset in_ready", 32'(in_ready), 32'd1);

    // R1 sweep of unsigned values, including the longest code
    send(0, 1'b0, 1'b1);
    for (int v = 1; v <= 300; v++) send(v, 1'b0, 1'b0);
    send(65534, 1'b0, 1'b0);
    send(65533, 1'b0, 1'b0);
    do_flush();
    check("R3 byte count after unsigned sweep", 32'(cap_n - base), 32'(nbits / 8));
    check("R4 wr_ptr tracks bytes", 32'(wr_ptr), 32'(cap_n - base));
    compare("R1 unsigned code bytes", 0, nbits / 8);
    mark = nbits / 8;

    // R2 sweep of signed values, including magnitude limits
    for (int v = -150; v <= 150; v++) send(v, 1'b1, 1'b0);
    send(32767, 1'b1, 1'b0);
    send(-32767, 1'b1, 1'b0);
    do_flush();
    check("R2 byte count after signed sweep", 32'(cap_n - base), 32'(nbits / 8));
    compare("R2 signed code bytes", mark, nbits / 8);

    // R7 flush with no pending bits emits nothing
    mark = cap_n;
    do_flush();
    check("R7 empty flush emits nothing", 32'(cap_n - mark), 32'd0);
    check("R7 pointer unchanged on empty flush", 32'(wr_ptr), 32'(cap_n - base));

    // R7 short partial byte: ue(1) = 010 -> 0x40
    mark = nbits / 8;
    send(1, 1'b0, 1'b0);
    do_flush();
    compare("R7 padded partial byte", mark, nbits / 8);
    check("R7 padded value", 32'(cap[cap_n-1]), 32'h40);

    // R5 end-of-buffer stall mid-code
    do_reset(3);
    send(65534, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    check("R5 bytes stop at end", 32'(cap_n - base), 32'd3);
    check("R5 full raised", 32'(full), 32'd1);
    check("R5 ready low when full", 32'(in_ready), 32'd0);
    check("R5 wr_ptr at end", 32'(wr_ptr), 32'd3);
    compare("R5 bytes before stall", 0, 3);
    flush = 1'b1;
    repeat (3) @(negedge clk);
    flush = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 flush ignored when full", 32'(cap_n - base), 32'd3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule